// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block arbitrates between five interrupt request sources and tells the CPU which vector to fetch. The sources are two external pins (active low), two timer overflow pulses, and one combined serial request. Software programs a per-source enable, a global enable, a per-source priority level (high or low) and, for each external pin, a choice between falling-edge and low-level detection. The programming goes through a small register port.

Arbitration runs once per machine cycle, which lasts a parameterised number of clocks. The controller presents a single vector and holds it until the CPU acknowledges. On acknowledge it marks the level as in service and clears the flags that hardware owns. A return strobe from the CPU retires the innermost level. A high-level request may preempt a low-level handler. Nothing preempts a high-level handler. Within a level, a fixed polling order decides between simultaneous requests.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, irqReq is 0, inService is 0, and the enable, priority and type registers read as 0.
- R2: The source indices are external0=0, timer0=1, external1=2, timer1=3, serial=4. Register select 0 is the enable register: bit 7 is the global enable and bits 4:0 enable the individual sources. Select 1 is the priority register: bits 4:0, where 1 means high. Select 2 is the type register: bits 1:0 for external0 and external1, where 1 means falling edge and 0 means low level. Select 3 reads the five request flags on bits 4:0. Selects 0 to 2 read back as written.
- R3: The vector issued for source index i is 0x0003 + 8*i.
- R4: A flagged source raises no request unless both its own enable bit and the global enable bit are 1.
- R5: Any eligible high-level source wins over any low-level source. Within one level, the lowest index wins.
- R6: A high-level request is accepted while only the low level is in service. A low-level request waits while either level is in service. No request is issued while the high level is in service.
- R7: An edge-type external flag sets on a synchronised falling edge of its pin. The flag clears when its vector is acknowledged.
- R8: A level-type external flag equals the inverted synchronised pin. Acknowledge does not clear it.
- R9: A timer flag sets on its overflow pulse and clears on acknowledge of its vector. The serial flag follows serialReq and acknowledge does not affect it.
- R10: irqReq stays high with a stable irqVector until irqAck. In the cycle after the acknowledge, irqReq is 0 and the inService bit of the taken level is set. No new request is evaluated before the next machine-cycle boundary.
- R11: retiStrobe clears the high inService bit if it is set, and otherwise clears the low bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extPinN | input | 2 | External request pins, active low |
| timerOvf | input | 2 | Timer overflow pulses, one clock wide |
| serialReq | input | 1 | Combined serial transmit/receive request |
| cfgWe | input | 1 | Register write strobe |
| cfgSel | input | 2 | Register select |
| cfgWdata | input | 8 | Register write data |
| cfgRdata | output | 8 | Register read data for cfgSel |
| irqAck | input | 1 | CPU acknowledges the pending vector |
| retiStrobe | input | 1 | Return from the current handler |
| irqReq | output | 1 | A vector is pending |
| irqVector | output | ADDR_W | Vector address of the pending request |
| inService | output | 2 | In-service bits, bit 1 high level, bit 0 low level |

## Verification
The bench builds the block with CYC_CLKS=4 so that machine-cycle boundaries come every fourth clock. This lets the windows in which a blocked request must stay silent span several arbitration points in a short run. SYNC_STAGES stays at 2, and the vector base and stride keep their defaults, so the expected vectors are the five fixed addresses. Directed scenarios set flags while the global enable is off and then release them all at once, which creates truly simultaneous requests for the ordering and preemption checks.

// File: rtl/irqPkg.sv
package irqPkg;
  localparam int SRC_N  = 5;
  localparam int IDX_W  = 3;
  localparam int EXT_N  = 2;
  localparam int TMR_N  = 2;
  localparam int SRC_SER = 4;
  localparam int REG_W  = 8;
  localparam int LVL_N  = 2;

  typedef struct packed {
    logic             capture;
    logic             take;
    logic             retire;
    logic [IDX_W-1:0] winIdx;
    logic             winHigh;
  } ctrlStrobe_t;

  function automatic logic [IDX_W-1:0] firstSet(input logic [SRC_N-1:0] v);
    logic [IDX_W-1:0] idx;
    idx = '0;
    for (int i = SRC_N - 1; i >= 0; i--) begin
      if (v[i]) idx = IDX_W'(i);
    end
    return idx;
  endfunction
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinN,
  output logic lowLevel,
  output logic fallPulse
);
  logic [STAGES-1:0] chain;
  logic              prevSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain    <= '1;
      prevSync <= 1'b1;
    end else begin
      chain    <= {chain[STAGES-2:0], pinN};
      prevSync <= chain[STAGES-1];
    end
  end

  assign lowLevel  = ~chain[STAGES-1];
  assign fallPulse = prevSync & ~chain[STAGES-1];
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irqPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 16,
  parameter int VEC_BASE    = 3,
  parameter int VEC_STRIDE  = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [EXT_N-1:0]        extPinN,
  input  logic [TMR_N-1:0]        timerOvf,
  input  logic                    serialReq,
  input  logic                    cfgWe,
  input  logic [1:0]              cfgSel,
  input  logic [REG_W-1:0]        cfgWdata,
  output logic [REG_W-1:0]        cfgRdata,
  input  ctrlStrobe_t             strb,
  output logic [SRC_N-1:0]        flags,
  output logic [SRC_N-1:0]        srcEn,
  output logic [SRC_N-1:0]        prioHigh,
  output logic                    glbEn,
  output logic [LVL_N-1:0]        inSvc,
  output logic [ADDR_W-1:0]       irqVector
);
  logic [REG_W-1:0] enReg, prioReg, typeReg;
  logic [SRC_N-1:0] flagQ, flagNext, takeHit;
  logic [EXT_N-1:0] extLow, extFall;
  logic [IDX_W-1:0] pendIdx;
  logic             pendHigh;
  logic [LVL_N-1:0] svcNext;

  // which source the acknowledge retires
  always_comb begin
    for (int i = 0; i < SRC_N; i++) begin
      takeHit[i] = strb.take && (pendIdx == IDX_W'(i));
    end
  end

  generate
    for (genvar e = 0; e < EXT_N; e++) begin : gExt
      irq_pin_sync #(.STAGES(SYNC_STAGES)) uSync (
        .clk      (clk),
        .rstN     (rstN),
        .pinN     (extPinN[e]),
        .lowLevel (extLow[e]),
        .fallPulse(extFall[e])
      );
      assign flagNext[2*e] = typeReg[e]
        ? (extFall[e] | (flagQ[2*e] & ~takeHit[2*e]))
        : extLow[e];
    end
    for (genvar t = 0; t < TMR_N; t++) begin : gTmr
      assign flagNext[2*t+1] = timerOvf[t] | (flagQ[2*t+1] & ~takeHit[2*t+1]);
    end
  endgenerate

  assign flagNext[SRC_SER] = serialReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagQ <= '0;
    else       flagQ <= flagNext;
  end

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg   <= '0;
      prioReg <= '0;
      typeReg <= '0;
    end else if (cfgWe) begin
      case (cfgSel)
        2'd0:    enReg   <= cfgWdata;
        2'd1:    prioReg <= cfgWdata;
        2'd2:    typeReg <= cfgWdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (cfgSel)
      2'd0:    cfgRdata = enReg;
      2'd1:    cfgRdata = prioReg;
      2'd2:    cfgRdata = typeReg;
      default: cfgRdata = REG_W'(flagQ);
    endcase
  end

  // in-service tracking: retire innermost, then mark taken level
  always_comb begin
    svcNext = inSvc;
    if (strb.retire) begin
      if (svcNext[1]) svcNext[1] = 1'b0;
      else            svcNext[0] = 1'b0;
    end
    if (strb.take) svcNext[pendHigh] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inSvc     <= '0;
      pendIdx   <= '0;
      pendHigh  <= 1'b0;
      irqVector <= '0;
    end else begin
      inSvc <= svcNext;
      if (strb.capture) begin
        pendIdx   <= strb.winIdx;
        pendHigh  <= strb.winHigh;
        irqVector <= ADDR_W'(VEC_BASE + int'(strb.winIdx) * VEC_STRIDE);
      end
    end
  end

  assign flags    = flagQ;
  assign srcEn    = enReg[SRC_N-1:0];
  assign glbEn    = enReg[REG_W-1];
  assign prioHigh = prioReg[SRC_N-1:0];
endmodule

// File: rtl/irq_control.sv
module irq_control
  import irqPkg::*;
#(
  parameter int CYC_CLKS = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SRC_N-1:0] flags,
  input  logic [SRC_N-1:0] srcEn,
  input  logic [SRC_N-1:0] prioHigh,
  input  logic             glbEn,
  input  logic [LVL_N-1:0] inSvc,
  input  logic             irqAck,
  input  logic             retiIn,
  output ctrlStrobe_t      strb,
  output logic             irqReq
);
  localparam int CNT_W = (CYC_CLKS > 2) ? $clog2(CYC_CLKS) : 1;

  logic [CNT_W-1:0] cycCnt;
  logic             tick;
  logic             pendQ;
  logic [SRC_N-1:0] eligible, hiCand, loCand;
  logic             anyHi, anyLo;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      cycCnt <= '0;
    else if (tick)  cycCnt <= '0;
    else            cycCnt <= cycCnt + 1'b1;
  end
  assign tick = (cycCnt == CNT_W'(CYC_CLKS - 1));

  assign eligible = flags & srcEn & {SRC_N{glbEn}};
  assign hiCand   = eligible & prioHigh  & {SRC_N{~inSvc[1]}};
  assign loCand   = eligible & ~prioHigh & {SRC_N{inSvc == '0}};
  assign anyHi    = |hiCand;
  assign anyLo    = |loCand;

  always_comb begin
    strb.take    = pendQ && irqAck;
    strb.retire  = retiIn;
    strb.capture = tick && !pendQ && (anyHi || anyLo);
    strb.winHigh = anyHi;
    strb.winIdx  = anyHi ? firstSet(hiCand) : firstSet(loCand);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             pendQ <= 1'b0;
    else if (strb.take)    pendQ <= 1'b0;
    else if (strb.capture) pendQ <= 1'b1;
  end

  assign irqReq = pendQ;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irqPkg::*;
#(
  parameter int CYC_CLKS    = 12,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 16,
  parameter int VEC_BASE    = 3,
  parameter int VEC_STRIDE  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        extPinN,
  input  logic [1:0]        timerOvf,
  input  logic              serialReq,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [7:0]        cfgWdata,
  output logic [7:0]        cfgRdata,
  input  logic              irqAck,
  input  logic              retiStrobe,
  output logic              irqReq,
  output logic [ADDR_W-1:0] irqVector,
  output logic [1:0]        inService
);
  ctrlStrobe_t      strb;
  logic [SRC_N-1:0] flags, srcEn, prioHigh;
  logic             glbEn;

  irq_datapath #(
    .SYNC_STAGES(SYNC_STAGES), .ADDR_W(ADDR_W),
    .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
  ) uDp (
    .clk(clk), .rstN(rstN), .extPinN(extPinN), .timerOvf(timerOvf),
    .serialReq(serialReq), .cfgWe(cfgWe), .cfgSel(cfgSel),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .strb(strb),
    .flags(flags), .srcEn(srcEn), .prioHigh(prioHigh), .glbEn(glbEn),
    .inSvc(inService), .irqVector(irqVector)
  );

  irq_control #(.CYC_CLKS(CYC_CLKS)) uCtl (
    .clk(clk), .rstN(rstN), .flags(flags), .srcEn(srcEn),
    .prioHigh(prioHigh), .glbEn(glbEn), .inSvc(inService),
    .irqAck(irqAck), .retiIn(retiStrobe), .strb(strb), .irqReq(irqReq)
  );
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int ADDR_W     = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              irqReq,
  input logic              irqAck,
  input logic              retiStrobe,
  input logic [ADDR_W-1:0] irqVector,
  input logic [1:0]        inService
);
  function automatic logic legalVec(input logic [ADDR_W-1:0] v);
    logic ok;
    ok = 1'b0;
    for (int i = 0; i < 5; i++) begin
      if (v == ADDR_W'(VEC_BASE + i * VEC_STRIDE)) ok = 1'b1;
    end
    return ok;
  endfunction

  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    !rstN |=> (!irqReq && inService == 2'b00));

  // R10
  a_r10_vec_stable: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && !irqAck) |=> (irqReq && $stable(irqVector)));

  // R10
  a_r10_single_vector: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && irqAck) |=> !irqReq);

  // R6
  a_r6_high_svc_blocks: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqReq) |-> !inService[1]);

  // R3
  a_r3_vector_legal: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> legalVec(irqVector));

  // R11
  a_r11_retire_high_first: assert property (@(posedge clk) disable iff (!rstN)
    (retiStrobe && !irqAck && inService == 2'b11) |=> (inService == 2'b01));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
  .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
) uChk (
  .clk(clk), .rstN(rstN), .irqReq(irqReq), .irqAck(irqAck),
  .retiStrobe(retiStrobe), .irqVector(irqVector), .inService(inService)
);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  localparam int CYC = 4;
  localparam int WIN = 4 * CYC + 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  extPinN = 2'b11;
  logic [1:0]  timerOvf = 2'b00;
  logic        serialReq = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgSel = 2'd0;
  logic [7:0]  cfgWdata = 8'd0;
  logic [7:0]  cfgRdata;
  logic        irqAck = 1'b0;
  logic        retiStrobe = 1'b0;
  logic        irqReq;
  logic [15:0] irqVector;
  logic [1:0]  inService;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl #(.CYC_CLKS(CYC)) uut (
    .clk(clk), .rstN(rstN), .extPinN(extPinN), .timerOvf(timerOvf),
    .serialReq(serialReq), .cfgWe(cfgWe), .cfgSel(cfgSel),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .irqAck(irqAck),
    .retiStrobe(retiStrobe), .irqReq(irqReq), .irqVector(irqVector),
    .inService(inService)
  );

  function automatic int vecOf(input int idx);
    return 3 + 8 * idx;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfgWrite(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = sel; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic cfgRead(input logic [1:0] sel, output logic [7:0] v);
    @(negedge clk);
    cfgSel = sel;
    #1 v = cfgRdata;
  endtask

  task automatic pulseTimer(input int t);
    @(negedge clk);
    timerOvf[t] = 1'b1;
    @(negedge clk);
    timerOvf[t] = 1'b0;
  endtask

  // wait for a request, check its vector, acknowledge it
  task automatic takeVec(input string tag, input int expVec);
    int waited = 0;
    while (!irqReq && waited < 10 * CYC + 20) begin
      @(negedge clk);
      waited++;
    end
    chk({tag, " request seen"}, int'(irqReq), 1);
    chk({tag, " vector"}, int'(irqVector), expVec);
    irqAck = 1'b1;
    @(negedge clk);
    irqAck = 1'b0;
  endtask

  task automatic retire();
    @(negedge clk);
    retiStrobe = 1'b1;
    @(negedge clk);
    retiStrobe = 1'b0;
  endtask

  task automatic noReq(input string tag);
    int seen = 0;
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      if (irqReq) seen = 1;
    end
    chk(tag, seen, 0);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 irqReq after reset", int'(irqReq), 0);
    chk("R1 inService after reset", int'(inService), 0);
    for (int s = 0; s < 3; s++) begin
      cfgRead(2'(s), v);
      chk("R1 register reset value", int'(v), 0);
    end
  endtask

  task automatic t_vectors();
    logic [7:0] v;
    cfgWrite(2'd2, 8'h03);
    cfgWrite(2'd1, 8'h00);
    cfgWrite(2'd0, 8'h9F);
    cfgRead(2'd0, v);
    chk("R2 enable readback", int'(v), 'h9F);
    for (int i = 0; i < 5; i++) begin
      if (i == 0 || i == 2) begin
        @(negedge clk); extPinN[i/2] = 1'b0;
      end else if (i == 1 || i == 3) begin
        pulseTimer(i/2);
      end else begin
        @(negedge clk); serialReq = 1'b1;
      end
      // R10: vector holds until acknowledged
      while (!irqReq) @(negedge clk);
      idle(3);
      chk("R10 request held", int'(irqReq), 1);
      takeVec("R3", vecOf(i));
      chk("R10 request dropped after ack", int'(irqReq), 0);
      chk("R10 low level in service", int'(inService), 1);
      cfgRead(2'd3, v);
      if (i < 4) chk("R7 R9 flag cleared on ack", int'(v[i]), 0);
      else       chk("R9 serial flag kept on ack", int'(v[4]), 1);
      if (i == 0 || i == 2) extPinN[i/2] = 1'b1;
      if (i == 4) begin serialReq = 1'b0; idle(3); end
      retire();
      chk("R11 retire clears low", int'(inService), 0);
    end
  endtask

  task automatic t_order();
    logic [7:0] v;
    cfgWrite(2'd0, 8'h1F);
    @(negedge clk); extPinN[1] = 1'b0; serialReq = 1'b1;
    pulseTimer(1);
    pulseTimer(0);
    idle(6);
    cfgRead(2'd3, v);
    chk("R2 R7 R9 flag register", int'(v), 'h1E);
    chk("R4 global enable off", int'(irqReq), 0);
    cfgWrite(2'd0, 8'h9F);
    takeVec("R5 order first timer0", vecOf(1));
    noReq("R6 same level waits");
    retire();
    takeVec("R5 order then external1", vecOf(2));
    retire();
    takeVec("R5 order then timer1", vecOf(3));
    retire();
    takeVec("R5 order then serial", vecOf(4));
    serialReq = 1'b0; extPinN[1] = 1'b1;
    idle(3);
    retire();
    // high level beats a lower index at low level
    cfgWrite(2'd0, 8'h1F);
    cfgWrite(2'd1, 8'h08);
    @(negedge clk); extPinN[0] = 1'b0;
    pulseTimer(1);
    idle(6);
    cfgWrite(2'd0, 8'h9F);
    takeVec("R5 high beats low", vecOf(3));
    chk("R10 high level in service", int'(inService), 2);
    noReq("R6 low blocked under high");
    retire();
    takeVec("R6 low after high retired", vecOf(0));
    extPinN[0] = 1'b1;
    retire();
    cfgWrite(2'd1, 8'h00);
  endtask

  task automatic t_preempt();
    cfgWrite(2'd1, 8'h09);
    pulseTimer(0);
    takeVec("R6 low taken", vecOf(1));
    chk("R6 low in service", int'(inService), 1);
    pulseTimer(1);
    takeVec("R6 high preempts low", vecOf(3));
    chk("R6 both in service", int'(inService), 3);
    @(negedge clk); extPinN[0] = 1'b0;
    pulseTimer(0);
    noReq("R6 high in service blocks all");
    retire();
    chk("R11 retire clears high first", int'(inService), 1);
    takeVec("R6 high preempts again", vecOf(0));
    extPinN[0] = 1'b1;
    retire();
    chk("R11 back to low only", int'(inService), 1);
    noReq("R6 low waits while low in service");
    retire();
    takeVec("R6 pending low after retire", vecOf(1));
    retire();
    cfgWrite(2'd1, 8'h00);
  endtask

  task automatic t_gating();
    logic [7:0] v;
    cfgWrite(2'd0, 8'h9D);
    pulseTimer(0);
    noReq("R4 source enable off");
    cfgRead(2'd3, v);
    chk("R4 flag still pending", int'(v[1]), 1);
    cfgWrite(2'd0, 8'h1F);
    noReq("R4 global enable off");
    cfgWrite(2'd0, 8'h9F);
    takeVec("R4 released", vecOf(1));
    retire();
  endtask

  task automatic t_level();
    logic [7:0] v;
    cfgWrite(2'd2, 8'h00);
    cfgRead(2'd2, v);
    chk("R2 type readback", int'(v), 0);
    @(negedge clk); extPinN[1] = 1'b0;
    idle(4);
    cfgRead(2'd3, v);
    chk("R8 level flag follows pin", int'(v[2]), 1);
    takeVec("R8 level vector", vecOf(2));
    idle(1);
    cfgRead(2'd3, v);
    chk("R8 level flag not cleared by ack", int'(v[2]), 1);
    extPinN[1] = 1'b1;
    idle(4);
    cfgRead(2'd3, v);
    chk("R8 level flag drops with pin", int'(v[2]), 0);
    retire();
    noReq("R8 no request after pin release");
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(2);
    t_reset();
    t_vectors();
    t_order();
    t_preempt();
    t_gating();
    t_level();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule